// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital engine of an 8-bit successive-approximation converter. A start request launches a conversion. The sequencer presents a trial code to an external DAC and reads back a one-bit comparator verdict. It then performs a binary search, one bit per decision slot, starting at the most significant bit. When all decisions are made, the final code is copied into an output latch and a done flag is raised. The trial code then goes back to half scale so the next conversion is ready.

The analog side decides how the input is acquired, and two sampling styles are offered. In the first, one hold command is issued a fixed number of clocks after the start and is kept until the conversion ends. In the second, no hold is given; instead a short sample strobe comes before each bit decision. The style is captured when the conversion starts. Timing is fully deterministic: with the default parameters, 20 clock edges pass from the edge that accepts the start to the edge that raises done.

Top module: `sar_sequencer`

## Requirements
- R1: Synchronous active-low reset (`rstN` low at a rising edge) clears `resultData` to 0 and `done`, `busy`, `holdCtl` to 0, and sets `trialCode` to 8'h80.
- R2: A high `startReq` sampled at a rising edge while `busy` is 0 starts a conversion. After that edge `busy` is 1 and `done` is 0.
- R3: Decisions run from bit 7 down to bit 0, one every 2 clocks. At a decision, the bit under trial is kept when `cmpHigh` is 1 (input at or above the trial level) and cleared when it is 0, and the next lower bit is set to 1. After the first decision (5 edges after the start edge) `trialCode` equals {decided bit 7, 1, 000000}. With an ideal comparator, `resultData` equals the input.
- R4: In single-sample mode (`sampleMode`=0 at start), `holdCtl` rises on the third rising edge after the start edge and stays high until the result is latched. `sampleStb` stays 0.
- R5: In multi-sample mode (`sampleMode`=1 at start), `sampleStb` is high for exactly 8 clock cycles, one at the start of each bit slot and before that slot's decision. `holdCtl` stays 0.
- R6: After the eighth decision, `latchStb` is high for exactly one cycle. At the edge that ends that cycle, `resultData` takes the final code and `trialCode` returns to 8'h80.
- R7: `done` rises at the same edge that loads `resultData`, which is 20 edges after the start edge. It stays high until the next start is accepted. `busy` falls at that same edge.
- R8: `startReq` while `busy` is 1 is ignored. The running conversion keeps its timing and result, and no new conversion follows.
- R9: `sampleMode` is sampled only when a start is accepted. Changes during a conversion have no effect.
- R10: A reset during a conversion aborts it and gives the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| startReq | input | 1 | Conversion start request |
| sampleMode | input | 1 | 0: single hold, 1: strobe before each decision |
| cmpHigh | input | 1 | Comparator: analog input at or above DAC level |
| trialCode | output | 8 | Trial code driven to the DAC |
| holdCtl | output | 1 | Track/hold control, high = hold |
| sampleStb | output | 1 | Per-decision sample strobe |
| latchStb | output | 1 | Result-latch strobe |
| resultData | output | 8 | Latched conversion result |
| done | output | 1 | Result latched and valid |
| busy | output | 1 | Conversion in progress |

## Verification
The bench drives an ideal comparator from the trial code. It exercises the end codes 8'h00 and 8'hFF and the exact half-scale input 8'h80. A keep/clear rule with the wrong polarity, or one that compares on the wrong side of the half-scale point, shows up as results that are off by one or inverted in these cases. The bench also measures the edge on which the hold rises, the number of strobes and the conversion length. An off-by-one counter moves the hold, adds or drops a strobe, or stretches the conversion. A start request and a mode flip injected mid-conversion catch a sequencer that restarts or changes style. A reset in the middle of a conversion catches any state that the reset leaves behind.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // widest bit index the strobe struct can carry (up to 16 bits)
  localparam int MAX_IDX_W = 4;

  typedef struct packed {
    logic                 decide;  // apply comparator verdict this edge
    logic [MAX_IDX_W-1:0] bitIdx;  // bit under trial
    logic                 latch;   // copy code into result latch
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int CLKS_PER_BIT = 2,
  parameter int HOLD_DELAY   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       sampleMode,
  output sarStrobe_t strb,
  output logic       holdCtl,
  output logic       sampleStb,
  output logic       latchStb,
  output logic       done,
  output logic       busy
);
  localparam int SUB_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int ACQ_W = (HOLD_DELAY > 1) ? $clog2(HOLD_DELAY) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLKS_PER_BIT - 1);
  localparam logic [ACQ_W-1:0] ACQ_LAST = ACQ_W'(HOLD_DELAY - 1);
  localparam logic [MAX_IDX_W-1:0] TOP_IDX = MAX_IDX_W'(WIDTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_BITS, ST_LATCH} seqState_t;

  seqState_t            state;
  logic [ACQ_W-1:0]     acqCnt;
  logic [SUB_W-1:0]     subCnt;
  logic [MAX_IDX_W-1:0] bitIdx;
  logic                 modeQ;
  logic                 holdQ;
  logic                 doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      acqCnt <= '0;
      subCnt <= '0;
      bitIdx <= TOP_IDX;
      modeQ  <= 1'b0;
      holdQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state  <= ST_ACQ;
            acqCnt <= '0;
            modeQ  <= sampleMode;
            doneQ  <= 1'b0;
          end
        end
        ST_ACQ: begin
          if (acqCnt == ACQ_LAST) begin
            state  <= ST_BITS;
            subCnt <= '0;
            bitIdx <= TOP_IDX;
            holdQ  <= !modeQ;
          end else begin
            acqCnt <= acqCnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (subCnt == SUB_LAST) begin
            subCnt <= '0;
            if (bitIdx == '0) state <= ST_LATCH;
            else              bitIdx <= bitIdx - 1'b1;
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_LATCH: begin
          state <= ST_IDLE;
          holdQ <= 1'b0;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.decide = (state == ST_BITS) && (subCnt == SUB_LAST);
    strb.bitIdx = bitIdx;
    strb.latch  = (state == ST_LATCH);
  end

  assign holdCtl   = holdQ;
  assign sampleStb = modeQ && (state == ST_BITS) && (subCnt == '0);
  assign latchStb  = strb.latch;
  assign done      = doneQ;
  assign busy      = (state != ST_IDLE);

  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> $stable(modeQ));
  // R5
  strobe_no_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> !holdCtl);
  // R7
  done_after_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(strb.latch));
  // R4
  hold_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCtl |-> busy);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strb,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] resultData
);
  localparam logic [WIDTH-1:0] HALF = WIDTH'(1) << (WIDTH - 1);

  logic [WIDTH-1:0] trialQ;
  logic [WIDTH-1:0] resultQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam logic RST_VAL = (i == WIDTH - 1);
    always_ff @(posedge clk) begin
      if (!rstN || strb.latch) begin
        trialQ[i] <= RST_VAL;
      end else if (strb.decide) begin
        if (strb.bitIdx == MAX_IDX_W'(i))
          trialQ[i] <= cmpHigh;
        else if (strb.bitIdx == MAX_IDX_W'(i + 1))
          trialQ[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           resultQ <= '0;
    else if (strb.latch) resultQ <= trialQ;
  end

  assign trialCode  = trialQ;
  assign resultData = resultQ;

  // R6
  half_after_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |=> (trialQ == HALF));
  // R6
  result_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |=> (resultQ == $past(trialQ)));
  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latch |=> $stable(resultQ));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int CLKS_PER_BIT = 2,
  parameter int HOLD_DELAY   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             sampleMode,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic             holdCtl,
  output logic             sampleStb,
  output logic             latchStb,
  output logic [WIDTH-1:0] resultData,
  output logic             done,
  output logic             busy
);
  localparam logic [WIDTH-1:0] HALF = WIDTH'(1) << (WIDTH - 1);

  sarStrobe_t strb;

  sar_ctrl #(
    .WIDTH(WIDTH), .CLKS_PER_BIT(CLKS_PER_BIT), .HOLD_DELAY(HOLD_DELAY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sampleMode(sampleMode),
    .strb(strb), .holdCtl(holdCtl), .sampleStb(sampleStb),
    .latchStb(latchStb), .done(done), .busy(busy)
  );

  sar_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .resultData(resultData)
  );

  // R1
  idle_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (trialCode == HALF));
  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
  logic       clk = 1'b0;
  logic       rstN, startReq, sampleMode, cmpHigh;
  logic [7:0] trialCode, resultData, stimVal;
  logic       holdCtl, sampleStb, latchStb, done, busy;
  int         nChecks = 0;
  int         nFails  = 0;

  always #5 clk = ~clk;

  // ideal comparator: input at or above DAC level
  assign cmpHigh = (stimVal >= trialCode);

  sar_sequencer uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sampleMode(sampleMode),
    .cmpHigh(cmpHigh), .trialCode(trialCode), .holdCtl(holdCtl),
    .sampleStb(sampleStb), .latchStb(latchStb), .resultData(resultData),
    .done(done), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic convert(input logic mode, input logic [7:0] val, input bit disturb);
    int holdAt, doneAt, strobes, latches;
    @(negedge clk);
    stimVal = val; sampleMode = mode; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R2 busy after start", busy, 1);
    chk("R2 done cleared", done, 0);
    holdAt = -1; doneAt = -1; strobes = 0; latches = 0;
    for (int cyc = 1; cyc <= 30 && doneAt < 0; cyc++) begin
      if (disturb && cyc == 8) begin startReq = 1'b1; sampleMode = ~mode; end
      if (disturb && cyc == 9) startReq = 1'b0;
      @(negedge clk);
      if (sampleStb) strobes++;
      if (latchStb) latches++;
      if (holdCtl && holdAt < 0) holdAt = cyc;
      if (cyc == 5) chk("R3 first decision", trialCode, {val[7], 1'b1, 6'b0});
      if (done) doneAt = cyc;
    end
    chk(disturb ? "R8 latency" : "R7 latency", doneAt, 20);
    chk("R3 result", resultData, val);
    chk("R6 half scale", trialCode, 8'h80);
    chk("R6 latch pulses", latches, 1);
    chk("R7 busy low", busy, 0);
    chk("R4 hold released", holdCtl, 0);
    if (!mode) begin
      chk(disturb ? "R9 hold edge" : "R4 hold edge", holdAt, 3);
      chk("R4 no strobes", strobes, 0);
    end else begin
      chk(disturb ? "R9 no hold" : "R5 no hold", holdAt, -1);
      chk("R5 strobe count", strobes, 8);
    end
    if (disturb) begin
      repeat (3) @(negedge clk);
      chk("R8 no restart busy", busy, 0);
      chk("R8 done held", done, 1);
    end
  endtask

  task automatic reset_mid;
    @(negedge clk);
    stimVal = 8'h99; sampleMode = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (9) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 result cleared", resultData, 0);
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 hold", holdCtl, 0);
    chk("R10 trial", trialCode, 8'h80);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; startReq = 1'b0; sampleMode = 1'b0; stimVal = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 result", resultData, 0);
    chk("R1 trial", trialCode, 8'h80);
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 hold", holdCtl, 0);
    rstN = 1'b1;
    convert(1'b0, 8'h00, 1'b0);
    convert(1'b0, 8'hFF, 1'b0);
    convert(1'b0, 8'h80, 1'b0);
    convert(1'b0, 8'h5A, 1'b0);
    convert(1'b1, 8'h01, 1'b0);
    convert(1'b1, 8'hA5, 1'b0);
    convert(1'b1, 8'h7F, 1'b0);
    convert(1'b0, 8'h3C, 1'b1);
    convert(1'b1, 8'hC3, 1'b1);
    reset_mid();
    convert(1'b1, 8'h80, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule